// File: doc/BRIEF.md
# Indexed Effective Address Calculator

This block forms the operand address for register-indirect addressing with an index register. Each request carries a 16-bit brief index extension word, a base address and the size of the operand access. The block reads the selected data or address register from the register-file snapshot on its inputs. The index value may be sign-extended from its low half. It is then optionally scaled and added to the base and to the sign-extended 8-bit displacement, using 32-bit wrap-around arithmetic.

A mode input picks one of two behaviours. In extended mode the scale field is honoured, word and long accesses may fall on odd addresses, and a set format flag is rejected as an unsupported format. In legacy mode the scale and format bits are read as zero and never flagged, so the index is always used unscaled. In that mode a word or long access to an odd address raises an address error in place of an address.

Requests use a valid/ready handshake. The result and both error flags appear from a register exactly one cycle after a request is accepted.

Top module: `idx_ea_calc`

## Requirements
- R1: Extension word bit 15 selects a data register (0) or an address register (1), and bits 14..12 give the register number 0..7.
- R2: With bit 11 at 0 the low 16 bits of the selected register are sign-extended to 32 bits; with bit 11 at 1 the whole 32-bit register is the index.
- R3: In extended mode (mode_ext=1) the scale field in bits 10..9 multiplies the index by 1, 2, 4 or 8 for the codes 0, 1, 2 and 3.
- R4: The address is base plus the sign-extended displacement in bits 7..0 plus the scaled index, taken modulo 2^32.
- R5: In legacy mode (mode_ext=0) the scale bits and the format flag (bit 8) are read as zero: the index is unscaled and res_fmt_err stays 0.
- R6: In legacy mode a word or long access (op_size 1, 2 or 3) to an odd address gives res_addr_err=1 and res_addr=0.
- R7: In extended mode a word or long access to an odd address is legal: res_addr_err stays 0 and the odd address is delivered.
- R8: A byte access (op_size 0) never raises res_addr_err in either mode.
- R9: In extended mode an extension word with bit 8 set gives res_fmt_err=1, res_addr_err=0 and res_addr=0.
- R10: An accepted request (req_valid and req_ready both high at a clock edge) produces res_valid high for the one following cycle. While res_valid is low, res_addr and both error flags are 0.
- R11: While rst_n is low, req_ready and res_valid are 0. After the first clock edge with rst_n high, req_ready is 1 and stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts a request |
| mode_ext | input | 1 | 1 = extended mode, 0 = legacy mode |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 long |
| ext_word | input | 16 | Brief index extension word |
| base_addr | input | 32 | Base address register value |
| data_regs | input | 256 | Data registers 0..7, register i in bits [32*i+31:32*i] |
| addr_regs | input | 256 | Address registers 0..7, register i in bits [32*i+31:32*i] |
| res_valid | output | 1 | Result present, one cycle after acceptance |
| res_addr | output | 32 | Effective address, 0 on any error |
| res_addr_err | output | 1 | Odd word/long access in legacy mode |
| res_fmt_err | output | 1 | Full-format extension word in extended mode |

## Verification
In legacy mode, dropping the scale bits and raising the odd-address trap can happen on the same request. A scale that would have made the index even, but is ignored, leaves an odd sum. The bench drives such words, with the format bit also set, in legacy long and word accesses. It expects an address error with no format error and a zero address, and runs the same word in extended mode for contrast. The bench also checks the reverse case, where the ignored scale leaves an even legacy address that must come out unscaled and without error.

// File: rtl/idx_ea_pkg.sv
package idx_ea_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE     = 2'd0,
      SZ_WORD     = 2'd1,
      SZ_LONG     = 2'd2,
      SZ_LONG_ALT = 2'd3
   } op_size_e;

   // Brief extension word, with the fields that feed the address path
   typedef struct packed {
      logic       is_addr;
      logic [2:0] regnum;
      logic       long_idx;
      logic [1:0] scale;
      logic [7:0] disp;
   } ext_fields_t;

   // Word and long accesses are the ones that care about alignment
   function automatic logic size_is_multibyte(input logic [1:0] sz);
      return op_size_e'(sz) != SZ_BYTE;
   endfunction

endpackage

// File: rtl/idx_ea_extdec.sv
module idx_ea_extdec
   import idx_ea_pkg::*;
(
   input  logic [15:0]  ext_word,
   input  logic         mode_ext,
   output ext_fields_t  fields,
   output logic         fmt_reject
);

   always_comb begin
      fields.is_addr  = ext_word[15];
      fields.regnum   = ext_word[14:12];
      fields.long_idx = ext_word[11];
      // legacy mode reads the scale bits as zero
      fields.scale    = mode_ext ? ext_word[10:9] : 2'b00;
      fields.disp     = ext_word[7:0];
      // the format flag is only meaningful in extended mode
      fmt_reject      = mode_ext & ext_word[8];
   end

endmodule

// File: rtl/idx_ea_index.sv
module idx_ea_index #(
   parameter int ADDR_W     = 32,
   parameter int NUM_REGS   = 8,
   parameter int SHORT_W    = 16,
   parameter int SCALE_IMPL = 0
) (
   input  logic [NUM_REGS*ADDR_W-1:0] data_regs,
   input  logic [NUM_REGS*ADDR_W-1:0] addr_regs,
   input  logic                       is_addr,
   input  logic [$clog2(NUM_REGS)-1:0] regnum,
   input  logic                       long_idx,
   input  logic [1:0]                 scale,
   output logic [ADDR_W-1:0]          idx_scaled
);

   localparam int EXT_W = ADDR_W - SHORT_W;

   logic [ADDR_W-1:0] bank_d [NUM_REGS];
   logic [ADDR_W-1:0] bank_a [NUM_REGS];
   logic [ADDR_W-1:0] raw;
   logic [ADDR_W-1:0] idx_val;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
      assign bank_d[g] = data_regs[g*ADDR_W +: ADDR_W];
      assign bank_a[g] = addr_regs[g*ADDR_W +: ADDR_W];
   end

   assign raw = is_addr ? bank_a[regnum] : bank_d[regnum];

   always_comb begin
      if (long_idx) idx_val = raw;
      else          idx_val = {{EXT_W{raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
   end

   if (SCALE_IMPL == 0) begin : g_shift
      assign idx_scaled = idx_val << scale;
   end else begin : g_mux
      always_comb begin
         unique case (scale)
            2'd0: idx_scaled = idx_val;
            2'd1: idx_scaled = {idx_val[ADDR_W-2:0], 1'b0};
            2'd2: idx_scaled = {idx_val[ADDR_W-3:0], 2'b00};
            default: idx_scaled = {idx_val[ADDR_W-4:0], 3'b000};
         endcase
      end
   end

endmodule

// File: rtl/idx_ea_sum.sv
module idx_ea_sum #(
   parameter int ADDR_W  = 32,
   parameter int DISP_W  = 8,
   parameter int USE_CSA = 1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   input  logic [ADDR_W-1:0] idx,
   output logic [ADDR_W-1:0] ea
);

   localparam int PAD_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_x;
   assign disp_x = {{PAD_W{disp[DISP_W-1]}}, disp};

   if (USE_CSA != 0) begin : g_csa
      logic [ADDR_W-1:0] s_vec;
      logic [ADDR_W-1:0] c_vec;
      logic [ADDR_W-1:0] maj;
      assign s_vec = base ^ disp_x ^ idx;
      assign maj   = (base & disp_x) | (base & idx) | (disp_x & idx);
      assign c_vec = {maj[ADDR_W-2:0], 1'b0};
      assign ea    = s_vec + c_vec;
   end else begin : g_ripple
      assign ea = base + disp_x + idx;
   end

endmodule

// File: rtl/idx_ea_result.sv
module idx_ea_result #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              align_trap_en,
   input  logic              fmt_reject,
   input  logic [ADDR_W-1:0] ea,
   output logic              ready,
   output logic              res_valid,
   output logic [ADDR_W-1:0] res_addr,
   output logic              res_addr_err,
   output logic              res_fmt_err
);

   logic misaligned;
   assign misaligned = align_trap_en & ea[0] & ~fmt_reject;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready        <= 1'b0;
         res_valid    <= 1'b0;
         res_addr     <= '0;
         res_addr_err <= 1'b0;
         res_fmt_err  <= 1'b0;
      end else begin
         ready <= 1'b1;
         if (accept) begin
            res_valid    <= 1'b1;
            res_addr_err <= misaligned;
            res_fmt_err  <= fmt_reject;
            res_addr     <= (misaligned | fmt_reject) ? '0 : ea;
         end else begin
            res_valid    <= 1'b0;
            res_addr_err <= 1'b0;
            res_fmt_err  <= 1'b0;
            res_addr     <= '0;
         end
      end
   end

endmodule

// File: rtl/idx_ea_calc.sv
module idx_ea_calc
   import idx_ea_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NUM_REGS   = 8,
   parameter int SHORT_W    = 16,
   parameter int DISP_W     = 8,
   parameter int SCALE_IMPL = 0,
   parameter int USE_CSA    = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       mode_ext,
   input  logic [1:0]                 op_size,
   input  logic [15:0]                ext_word,
   input  logic [ADDR_W-1:0]          base_addr,
   input  logic [NUM_REGS*ADDR_W-1:0] data_regs,
   input  logic [NUM_REGS*ADDR_W-1:0] addr_regs,
   output logic                       res_valid,
   output logic [ADDR_W-1:0]          res_addr,
   output logic                       res_addr_err,
   output logic                       res_fmt_err
);

   localparam int REG_SEL_W = $clog2(NUM_REGS);

   if (NUM_REGS != 8) begin : g_chk_regs
      $error("idx_ea_calc: the extension word addresses exactly 8 registers per bank");
   end
   if (SHORT_W < 2 || SHORT_W >= ADDR_W) begin : g_chk_short
      $error("idx_ea_calc: SHORT_W must lie between 2 and ADDR_W-1");
   end
   if (DISP_W != 8) begin : g_chk_disp
      $error("idx_ea_calc: brief extension word carries an 8-bit displacement");
   end
   if (ADDR_W < 16) begin : g_chk_addr
      $error("idx_ea_calc: ADDR_W must be at least 16");
   end

   ext_fields_t       fld;
   logic              fmt_reject;
   logic [ADDR_W-1:0] idx_scaled;
   logic [ADDR_W-1:0] ea;
   logic              accept;
   logic              align_trap_en;

   idx_ea_extdec u_dec (
      .ext_word   (ext_word),
      .mode_ext   (mode_ext),
      .fields     (fld),
      .fmt_reject (fmt_reject)
   );

   idx_ea_index #(
      .ADDR_W     (ADDR_W),
      .NUM_REGS   (NUM_REGS),
      .SHORT_W    (SHORT_W),
      .SCALE_IMPL (SCALE_IMPL)
   ) u_idx (
      .data_regs  (data_regs),
      .addr_regs  (addr_regs),
      .is_addr    (fld.is_addr),
      .regnum     (fld.regnum[REG_SEL_W-1:0]),
      .long_idx   (fld.long_idx),
      .scale      (fld.scale),
      .idx_scaled (idx_scaled)
   );

   idx_ea_sum #(
      .ADDR_W  (ADDR_W),
      .DISP_W  (DISP_W),
      .USE_CSA (USE_CSA)
   ) u_sum (
      .base (base_addr),
      .disp (fld.disp[DISP_W-1:0]),
      .idx  (idx_scaled),
      .ea   (ea)
   );

   assign accept        = req_valid & req_ready;
   assign align_trap_en = ~mode_ext & size_is_multibyte(op_size);

   idx_ea_result #(
      .ADDR_W (ADDR_W)
   ) u_res (
      .clk           (clk),
      .rst_n         (rst_n),
      .accept        (accept),
      .align_trap_en (align_trap_en),
      .fmt_reject    (fmt_reject),
      .ea            (ea),
      .ready         (req_ready),
      .res_valid     (res_valid),
      .res_addr      (res_addr),
      .res_addr_err  (res_addr_err),
      .res_fmt_err   (res_fmt_err)
   );

endmodule

// File: rtl/idx_ea_chk.sv
module idx_ea_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              mode_ext,
   input logic [1:0]        op_size,
   input logic [15:0]       ext_word,
   input logic              res_valid,
   input logic [ADDR_W-1:0] res_addr,
   input logic              res_addr_err,
   input logic              res_fmt_err
);

   logic acc;
   assign acc = req_valid & req_ready;

   p_accept_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> res_valid);

   p_no_spurious_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> !res_valid);

   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (res_addr == '0 && !res_addr_err && !res_fmt_err));

   p_legacy_no_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !mode_ext) |=> !res_fmt_err);

   p_legacy_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !mode_ext && op_size != 2'd0) |=> (res_addr_err || !res_addr[0]));

   p_addr_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_addr_err |-> res_addr == '0);

   p_ext_no_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mode_ext) |=> !res_addr_err);

   p_byte_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op_size == 2'd0) |=> !res_addr_err);

   p_fmt_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && mode_ext && ext_word[8]) |=> (res_fmt_err && res_addr == '0));

   p_ready_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> req_ready);

   always_comb begin
      if (!rst_n) begin
         a_reset_quiet_r11: assert (!res_valid);
      end
   end

endmodule

bind idx_ea_calc idx_ea_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .mode_ext     (mode_ext),
   .op_size      (op_size),
   .ext_word     (ext_word),
   .res_valid    (res_valid),
   .res_addr     (res_addr),
   .res_addr_err (res_addr_err),
   .res_fmt_err  (res_fmt_err)
);

// File: tb/sim_idx_ea_calc.sv
`timescale 1ns/1ps
module sim_idx_ea_calc;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic         mode_ext = 1'b0;
   logic [1:0]   op_size = 2'd0;
   logic [15:0]  ext_word = 16'h0;
   logic [31:0]  base_addr = 32'h0;
   logic [255:0] data_regs;
   logic [255:0] addr_regs;
   logic         res_valid;
   logic [31:0]  res_addr;
   logic         res_addr_err;
   logic         res_fmt_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   idx_ea_calc u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .mode_ext(mode_ext), .op_size(op_size), .ext_word(ext_word),
      .base_addr(base_addr), .data_regs(data_regs), .addr_regs(addr_regs),
      .res_valid(res_valid), .res_addr(res_addr),
      .res_addr_err(res_addr_err), .res_fmt_err(res_fmt_err)
   );

   // D0..D7 and A0..A7 snapshot
   assign data_regs = {32'h0000_0003, 32'h0000_0100, 32'hFFFF_FFFE, 32'h0000_0010,
                       32'h0001_0004, 32'h0000_8000, 32'h0000_0001, 32'h0000_0000};
   assign addr_regs = {32'h0000_0700, 32'h0000_0600, 32'h0000_0500, 32'h0000_0400,
                       32'h0000_0300, 32'h0000_FFFF, 32'h0000_2000, 32'h0000_1000};

   typedef struct packed {
      logic        mode;
      logic [1:0]  size;
      logic [15:0] ext;
      logic [31:0] base;
      logic [31:0] exp_addr;
      logic        exp_ae;
      logic        exp_fe;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd2, 16'h7C20, 32'h0000_1000, 32'h0000_102C, 1'b0, 1'b0, 4'd3},  // D7.L*4 +32
      '{1'b0, 2'd2, 16'h7C20, 32'h0000_1000, 32'h0000_0000, 1'b1, 1'b0, 4'd6},  // scale dropped, odd
      '{1'b0, 2'd0, 16'h7C20, 32'h0000_1000, 32'h0000_1023, 1'b0, 1'b0, 4'd8},  // byte odd ok
      '{1'b1, 2'd1, 16'h7820, 32'h0000_1000, 32'h0000_1023, 1'b0, 1'b0, 4'd7},  // odd word legal
      '{1'b1, 2'd2, 16'h7D20, 32'h0000_1000, 32'h0000_0000, 1'b0, 1'b1, 4'd9},  // full format
      '{1'b0, 2'd2, 16'h7D20, 32'h0000_1001, 32'h0000_1024, 1'b0, 1'b0, 4'd5},  // fmt+scale ignored
      '{1'b1, 2'd2, 16'h2000, 32'h0001_0000, 32'h0000_8000, 1'b0, 1'b0, 4'd2},  // D2.W negative
      '{1'b1, 2'd2, 16'h2800, 32'h0001_0000, 32'h0001_8000, 1'b0, 1'b0, 4'd2},  // D2.L
      '{1'b1, 2'd2, 16'h8A80, 32'h0000_2000, 32'h0000_3F80, 1'b0, 1'b0, 4'd4},  // disp -128, A0*2
      '{1'b1, 2'd1, 16'hA604, 32'h0000_0100, 32'h0000_00FC, 1'b0, 1'b0, 4'd3},  // A2.W*8 = -8
      '{1'b1, 2'd0, 16'h687F, 32'hFFFF_FFF0, 32'h0000_016F, 1'b0, 1'b0, 4'd4},  // wrap
      '{1'b0, 2'd2, 16'h4E02, 32'h0000_0000, 32'h0000_0012, 1'b0, 1'b0, 4'd5},  // scale 8 dropped
      '{1'b1, 2'd2, 16'h4E02, 32'h0000_0000, 32'h0000_0082, 1'b0, 1'b0, 4'd3},  // scale 8 used
      '{1'b0, 2'd1, 16'h1000, 32'h0000_2000, 32'h0000_0000, 1'b1, 1'b0, 4'd6},  // odd word trap
      '{1'b1, 2'd1, 16'h1200, 32'h0000_2000, 32'h0000_2002, 1'b0, 1'b0, 4'd3},  // D1*2
      '{1'b0, 2'd1, 16'h1200, 32'h0000_2000, 32'h0000_0000, 1'b1, 1'b0, 4'd6},  // D1 unscaled odd
      '{1'b0, 2'd3, 16'h1000, 32'h0000_2000, 32'h0000_0000, 1'b1, 1'b0, 4'd6},  // size code 3
      '{1'b0, 2'd0, 16'hF0FF, 32'h0000_0000, 32'h0000_06FF, 1'b0, 1'b0, 4'd1},  // A7.W -1 byte
      '{1'b1, 2'd2, 16'h8800, 32'h0000_0000, 32'h0000_1000, 1'b0, 1'b0, 4'd1},  // A0
      '{1'b1, 2'd2, 16'h0800, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 4'd1}   // D0
   };

   function automatic string rq_name(input logic [3:0] r);
      case (r)
         4'd1: return "R1";
         4'd2: return "R2";
         4'd3: return "R3";
         4'd4: return "R4";
         4'd5: return "R5";
         4'd6: return "R6";
         4'd7: return "R7";
         4'd8: return "R8";
         4'd9: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [34:0] act, input logic [34:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL R10 watchdog expired: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      // R11: quiet during reset
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0 && res_valid == 1'b0, "R11", "reset ready/valid",
          {33'h0, req_ready, res_valid}, 35'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R11", "ready after reset", {34'h0, req_ready}, 35'h1);

      // vector table, back to back
      for (int i = 0; i < NV; i++) begin
         mode_ext  = VECS[i].mode;
         op_size   = VECS[i].size;
         ext_word  = VECS[i].ext;
         base_addr = VECS[i].base;
         req_valid = 1'b1;
         @(negedge clk);
         chk(res_valid && res_addr == VECS[i].exp_addr && res_addr_err == VECS[i].exp_ae
             && res_fmt_err == VECS[i].exp_fe, rq_name(VECS[i].rq),
             $sformatf("vector %0d {valid,aerr,ferr,addr}", i),
             {res_valid, res_addr_err, res_fmt_err, res_addr},
             {1'b1, VECS[i].exp_ae, VECS[i].exp_fe, VECS[i].exp_addr});
      end

      // R10: no request -> quiet outputs even with erroring inputs present
      req_valid = 1'b0;
      mode_ext  = 1'b1;
      ext_word  = 16'h7D20;
      @(negedge clk);
      chk(!res_valid && res_addr == 32'h0 && !res_addr_err && !res_fmt_err, "R10",
          "idle outputs", {res_valid, res_addr_err, res_fmt_err, res_addr}, 35'h0);

      // R10: single pulse after one accepted request
      mode_ext  = 1'b1;
      op_size   = 2'd2;
      ext_word  = 16'h7C20;
      base_addr = 32'h0000_1000;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(res_valid && res_addr == 32'h0000_102C, "R10", "pulse cycle",
          {res_valid, 2'b00, res_addr}, {1'b1, 2'b00, 32'h0000_102C});
      @(negedge clk);
      chk(!res_valid, "R10", "pulse ends", {34'h0, res_valid}, 35'h0);

      // R5/R6 together: legacy, format bit set, scale would have evened it
      mode_ext  = 1'b0;
      op_size   = 2'd1;
      ext_word  = 16'h1700;   // D1.W, scale 3, format 1, disp 0
      base_addr = 32'h0000_4000;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(res_valid && res_addr_err && !res_fmt_err && res_addr == 32'h0, "R6",
          "legacy ignored scale with odd trap", {res_valid, res_addr_err, res_fmt_err, res_addr},
          {1'b1, 1'b1, 1'b0, 32'h0});

      // same word, extended: format reject wins, no address error (R9)
      mode_ext  = 1'b1;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(res_valid && !res_addr_err && res_fmt_err && res_addr == 32'h0, "R9",
          "extended format reject", {res_valid, res_addr_err, res_fmt_err, res_addr},
          {1'b1, 1'b0, 1'b1, 32'h0});

      // R11: ready remains high through idle
      @(negedge clk);
      chk(req_ready == 1'b1, "R11", "ready held", {34'h0, req_ready}, 35'h1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule